// File: doc/BRIEF.md
# Byte-Lane Data Memory with Sized Writes

This block is a small data store addressed by bytes. A 2-bit operation code picks one of four accesses: an aligned word read, a byte write, an aligned halfword write or an aligned word write. The storage is split into four byte lanes. A partial write therefore touches only the lanes it addresses, and every other byte keeps its value.

A processor datapath drives the address, the write data, an enable and the operation code in the same cycle. A read is combinational and returns the word at once. A write is committed on the next rising clock edge. If an access breaks the alignment rule for its size, the block raises an error flag for that cycle and leaves the storage untouched. The depth is a parameter. Only the address bits that the depth needs are decoded, so higher addresses alias onto the same storage.

Top module: `bytelane_mem`

## Requirements
- R1: A synchronous active-high reset clears every stored byte to zero, so each aligned word read after reset returns 0.
- R2: With `en` high, `ctl`=00 and `addr[1:0]`=00, `rdata` shows the stored word in the same cycle, little-endian: the byte at `addr` is on bits 7:0 and the byte at `addr+3` is on bits 31:24.
- R3: `rdata` is zero whenever `en` is low, whenever `ctl` is a write code (01, 10, 11), and whenever a read is misaligned.
- R4: `ctl`=01 with `en` high writes `wdata[7:0]` into the byte at `addr` on the next rising edge, at any alignment, and leaves the other three bytes of that word unchanged.
- R5: `ctl`=10 with `en` high and `addr[0]`=0 writes `wdata[15:0]` into the bytes at `addr` (bits 7:0) and `addr+1` (bits 15:8), and leaves the other two bytes unchanged.
- R6: `ctl`=11 with `en` high and `addr[1:0]`=00 writes all 32 bits of `wdata` into the addressed word.
- R7: `err` is high exactly when `en` is high and the access is misaligned: `ctl` 00 or 11 with `addr[1:0]`≠00, or `ctl` 10 with `addr[0]`=1. A byte write never raises `err`, and `err` stays low while `en` is low.
- R8: An access that raises `err` changes no stored byte.
- R9: While `en` is low, no write code changes any stored byte.
- R10: Only the low log2(`DEPTH_BYTES`) address bits are decoded. With the default depth of 64, addresses that differ only above bit 5 reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears storage |
| en | input | 1 | Access enable |
| ctl | input | 2 | Operation: 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data (low byte or low halfword used for partial writes) |
| rdata | output | 32 | Read word, zero unless a valid aligned read is enabled |
| err | output | 1 | Misalignment flag for the current access |

## Verification
The bench fills the upper bits of `wdata` with unrelated patterns during byte and halfword writes. A design that takes lane data from the wrong bits, or that writes the whole word, then corrupts the neighbouring bytes and fails the read-back. It writes each byte offset and both halfword offsets of a word in turn. A swapped lane order then shows up as a byte-reversed word. Misaligned writes are aimed at words that already hold known data, so a design that raises `err` but still stores the data is caught. Disabled writes, and accesses at addresses that differ only in the upper bits, check the enable gating and the aliasing onto the decoded bits.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_RD_WORD = 2'b00,
        OP_WR_BYTE = 2'b01,
        OP_WR_HALF = 2'b10,
        OP_WR_WORD = 2'b11
    } mem_op_e;

    typedef logic [LANES-1:0][LANE_W-1:0] lane_bus_t;

    typedef struct packed {
        logic             misaligned;
        logic [LANES-1:0] lane_we;
    } access_t;

    // Alignment rule per access size
    function automatic logic misaligned_f(mem_op_e op, logic [1:0] lo);
        case (op)
            OP_WR_BYTE: return 1'b0;
            OP_WR_HALF: return lo[0];
            default:    return |lo;
        endcase
    endfunction

    // Byte lanes a write touches
    function automatic logic [LANES-1:0] lane_mask_f(mem_op_e op, logic [1:0] lo);
        case (op)
            OP_WR_BYTE: return 4'b0001 << lo;
            OP_WR_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            OP_WR_WORD: return 4'b1111;
            default:    return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/access_decode.sv
module access_decode
    import bytelane_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              en,
    input  mem_op_e           op,
    input  logic [IDX_W-1:0]  addr_lo,
    output access_t           acc,
    output logic [IDX_W-3:0]  widx
);
    logic [1:0] lo;
    logic       bad;

    assign lo   = addr_lo[1:0];
    assign widx = addr_lo[IDX_W-1:2];
    assign bad  = misaligned_f(op, lo);

    always_comb begin
        acc.misaligned = en && bad;
        acc.lane_we    = (en && !bad) ? lane_mask_f(op, lo) : '0;
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import bytelane_pkg::*;
(
    input  mem_op_e              op,
    input  logic [WORD_W-1:0]    wdata,
    output lane_bus_t            lane_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HALF_LO = (i % 2) * LANE_W;
        localparam int WORD_LO = i * LANE_W;
        always_comb begin
            case (op)
                OP_WR_BYTE: lane_data[i] = wdata[LANE_W-1:0];
                OP_WR_HALF: lane_data[i] = wdata[HALF_LO +: LANE_W];
                default:    lane_data[i] = wdata[WORD_LO +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/byte_bank.sv
module byte_bank
    import bytelane_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WIDX_W-1:0] widx,
    input  lane_bus_t         lane_data,
    output logic [WORD_W-1:0] rd_word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WORDS; w++) cells[w] <= '0;
            end else if (lane_we[i]) begin
                cells[widx] <= lane_data[i];
            end
        end

        assign rd_word[i*LANE_W +: LANE_W] = cells[widx];
    end
endmodule

// File: rtl/bytelane_mem.sv
module bytelane_mem
    import bytelane_pkg::*;
#(
    parameter int DEPTH_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [1:0]  ctl,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err
);
    localparam int IDX_W  = $clog2(DEPTH_BYTES);
    localparam int WORDS  = DEPTH_BYTES / LANES;
    localparam int WIDX_W = IDX_W - 2;

    mem_op_e            op;
    access_t            acc;
    logic [WIDX_W-1:0]  widx;
    logic [LANES-1:0]   lane_we;
    lane_bus_t          lane_data;
    logic [WORD_W-1:0]  rd_word;
    logic               unused_hi;

    assign op        = mem_op_e'(ctl);
    assign unused_hi = ^addr[31:IDX_W];
    assign lane_we   = acc.lane_we;

    access_decode #(.IDX_W(IDX_W)) u_dec (
        .en      (en),
        .op      (op),
        .addr_lo (addr[IDX_W-1:0]),
        .acc     (acc),
        .widx    (widx)
    );

    lane_steer u_steer (
        .op        (op),
        .wdata     (wdata),
        .lane_data (lane_data)
    );

    byte_bank #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .lane_we   (lane_we),
        .widx      (widx),
        .lane_data (lane_data),
        .rd_word   (rd_word)
    );

    assign err   = acc.misaligned;
    assign rdata = (en && op == OP_RD_WORD && !acc.misaligned) ? rd_word : '0;
endmodule

// File: rtl/bytelane_mem_chk.sv
module bytelane_mem_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [1:0]  ctl,
    input logic [31:0] addr,
    input logic [31:0] rdata,
    input logic        err,
    input logic [3:0]  lane_we
);
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !en |-> rdata == 32'd0);

    assert_write_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (en && ctl != 2'b00) |-> rdata == 32'd0);

    assert_err_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> en);

    assert_byte_never_err_R4: assert property (@(posedge clk) disable iff (rst)
        (en && ctl == 2'b01) |-> !err);

    assert_no_write_on_err_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> lane_we == 4'b0000);

    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !en |-> lane_we == 4'b0000);

    assert_lane_count_R5: assert property (@(posedge clk) disable iff (rst)
        lane_we == 4'b0000 || $countones(lane_we) == 1 ||
        $countones(lane_we) == 2 || lane_we == 4'b1111);

    assert_read_stable_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && en && ctl == 2'b00 && !err) && en && ctl == 2'b00 &&
         !err && addr == $past(addr)) |-> rdata == $past(rdata));
endmodule

bind bytelane_mem bytelane_mem_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .ctl     (ctl),
    .addr    (addr),
    .rdata   (rdata),
    .err     (err),
    .lane_we (lane_we)
);

// File: tb/sim_bytelane_mem.sv
module sim_bytelane_mem;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  ctl = 2'b00;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    bytelane_mem #(.DEPTH_BYTES(DEPTH)) u0 (
        .clk(clk), .rst(rst), .en(en), .ctl(ctl),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    function automatic logic bad_align(logic [1:0] c, logic [31:0] a);
        if (c == 2'b01) return 1'b0;
        if (c == 2'b10) return a[0];
        return a[1:0] != 2'b00;
    endfunction

    function automatic logic [31:0] model_word(logic [31:0] a);
        int b;
        b = int'(a[5:0]) & ~3;
        return {model[b+3], model[b+2], model[b+1], model[b]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(logic e, logic [1:0] c, logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        en = e; ctl = c; addr = a; wdata = d;
        #1;
    endtask

    task automatic do_write(string req, logic [1:0] c, logic [31:0] a, logic [31:0] d);
        logic bad;
        int b;
        bad = bad_align(c, a);
        drive(1'b1, c, a, d);
        chk(req, "err on write", {31'd0, err}, {31'd0, bad});
        chk("R3", "rdata during write", rdata, 32'd0);
        b = int'(a[5:0]);
        if (!bad) begin
            case (c)
                2'b01: model[b] = d[7:0];
                2'b10: begin model[b] = d[7:0]; model[b+1] = d[15:8]; end
                2'b11: begin
                    model[b] = d[7:0];   model[b+1] = d[15:8];
                    model[b+2] = d[23:16]; model[b+3] = d[31:24];
                end
                default: ;
            endcase
        end
    endtask

    task automatic do_read(string req, logic [31:0] a);
        logic bad;
        bad = bad_align(2'b00, a);
        drive(1'b1, 2'b00, a, 32'hDEAD_BEEF);
        chk(req, "err on read", {31'd0, err}, {31'd0, bad});
        chk(req, "read word", rdata, bad ? 32'd0 : model_word(a));
    endtask

    task automatic idle();
        drive(1'b0, 2'b00, 32'd0, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R3", "rdata in reset idle", rdata, 32'd0);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        for (int w = 0; w < DEPTH; w += 4) do_read("R1", w);
    endtask

    task automatic t_word();
        do_write("R6", 2'b11, 32'd8, 32'h4433_2211);
        do_write("R6", 2'b11, 32'd60, 32'hCAFE_F00D);
        do_read("R6", 32'd8);
        do_read("R6", 32'd60);
        do_write("R4", 2'b01, 32'd9, 32'h1234_56AA);
        do_read("R2", 32'd8);
        chk("R2", "little-endian lane", model_word(8), 32'h4433_AA11);
    endtask

    task automatic t_bytes();
        do_write("R6", 2'b11, 32'd16, 32'hFFFF_FFFF);
        do_write("R4", 2'b01, 32'd16, 32'h5555_5501);
        do_read("R4", 32'd16);
        do_write("R4", 2'b01, 32'd17, 32'h6666_6602);
        do_write("R4", 2'b01, 32'd18, 32'h7777_7703);
        do_read("R4", 32'd16);
        do_write("R4", 2'b01, 32'd19, 32'h8888_8804);
        do_read("R4", 32'd16);
        chk("R4", "byte assembly", model_word(16), 32'h0403_0201);
    endtask

    task automatic t_half();
        do_write("R6", 2'b11, 32'd20, 32'h0000_0000);
        do_write("R5", 2'b10, 32'd20, 32'h9999_BEEF);
        do_read("R5", 32'd20);
        do_write("R5", 2'b10, 32'd22, 32'h1111_C0DE);
        do_read("R5", 32'd20);
        chk("R5", "half assembly", model_word(20), 32'hC0DE_BEEF);
    endtask

    task automatic t_misaligned();
        do_write("R6", 2'b11, 32'd24, 32'hA5A5_5A5A);
        do_write("R7", 2'b11, 32'd25, 32'h0BAD_0BAD);
        do_write("R7", 2'b11, 32'd26, 32'h0BAD_0BAD);
        do_write("R7", 2'b10, 32'd27, 32'h0000_1234);
        do_write("R7", 2'b10, 32'd25, 32'h0000_1234);
        do_read("R8", 32'd24);
        do_read("R7", 32'd26);
        chk("R3", "misaligned read rdata", rdata, 32'd0);
        do_read("R7", 32'd27);
        do_write("R7", 2'b01, 32'd27, 32'h0000_0077);
        do_read("R4", 32'd24);
    endtask

    task automatic t_disabled();
        drive(1'b0, 2'b11, 32'd8, 32'hFEED_FACE);
        chk("R3", "rdata disabled", rdata, 32'd0);
        chk("R7", "err disabled", {31'd0, err}, 32'd0);
        drive(1'b0, 2'b11, 32'd9, 32'hFEED_FACE);
        chk("R7", "err disabled misaligned", {31'd0, err}, 32'd0);
        drive(1'b0, 2'b01, 32'd16, 32'h0000_00EE);
        drive(1'b0, 2'b00, 32'd8, 32'd0);
        chk("R3", "disabled read rdata", rdata, 32'd0);
        do_read("R9", 32'd8);
        do_read("R9", 32'd16);
    endtask

    task automatic t_alias();
        do_write("R10", 2'b11, 32'hABCD_0030, 32'h1357_9BDF);
        do_read("R10", 32'h0000_0030);
        do_read("R10", 32'hFFFF_FF30);
        do_write("R10", 2'b01, 32'h8000_0072, 32'h0000_0042);
        do_read("R10", 32'h0000_0030);
        chk("R10", "alias byte", model_word(32'h30), 32'h1342_9BDF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_word();
        t_bytes();
        t_half();
        t_misaligned();
        t_disabled();
        t_alias();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule